// File: doc/BRIEF.md
# ARINC 429 Receive Channel Checker

This block is one receive channel for a two-wire, return-to-zero bipolar avionics bus. It takes the two already-digitised line levels (a "high" leg and a "low" leg) and removes short noise spikes from each leg with a confirmation counter. It then recovers one bit at every departure from the null level and shifts the bits into a 32-bit register. A null period of two bit times closes the word. At that point the channel judges the word's length, its parity and whether both legs were ever high together. It hands the word to a holding buffer together with one prioritised 3-bit status code.

The reader sees `word_avail` rise with the word and its code. It releases the buffer with `rd_done` after a full read, or with `rd_part` when it gave up part-way. A partial release is reported against the next word. A word that completes while the buffer is still unreleased replaces the buffered word and is marked as an overrun. The `speed_hi` input sets the word-closing gap for fast or slow traffic. The `test_en` input swaps the line legs for a test stimulus pair.

Top module: `a429_rx_channel`

## Requirements
- R1: After reset, `word_avail` is 0, `word_data` is all zeros and `err_code` is 000.
- R2: A word of exactly 32 bits with odd parity over all 32 bits is delivered with `err_code` 000. The first bit on the wire lands in `word_data[0]` and the last bit in `word_data[31]`. A bit is 1 when the high leg leaves null and 0 when the low leg leaves null.
- R3: A word whose bit count is not 32 (short, or 33 and more) is delivered with `err_code` 011.
- R4: A 32-bit word with even parity is delivered with `err_code` 010.
- R5: If both legs are high together at any time during a word, the word gets `err_code` 111. This code outranks every other code. Codes 101 and 110 never appear.
- R6: A word that completes while `word_avail` is 1 and no release is given in that cycle replaces the buffered word with `err_code` 100. This code ranks below 111 and above 011.
- R7: A `rd_part` release of a buffered word makes the next delivered word carry `err_code` 001, when no higher code applies. The word after that is not affected.
- R8: A release (`rd_done` or `rd_part`) while `word_avail` is 1 clears `word_avail` one cycle later. A release while `word_avail` is 0 has no effect, and in particular does not mark the next word.
- R9: A pulse on either leg lasting fewer than `FILT_CLKS` clocks is ignored. A pulse of `FILT_CLKS` clocks or more is taken as a bit.
- R10: A word closes after a null run of 2·`HS_BIT_CLKS` clocks when `speed_hi` is 1, and of 2·`HS_BIT_CLKS`·`LS_RATIO` clocks when it is 0. At slow speed, two bursts separated by a shorter null run join into one word.
- R11: With `test_en` at 1, the channel decodes `test_hi`/`test_lo` and ignores `line_hi`/`line_lo`.
- R12: If a release and a word completion fall in the same cycle, the new word is delivered with `word_avail` staying 1 and no overrun code. A `rd_part` given in that cycle marks the new word with 001.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_hi | input | 1 | 1: fast bit rate gap, 0: slow bit rate gap |
| test_en | input | 1 | Select the test stimulus pair instead of the line |
| line_hi | input | 1 | Digitised high leg of the bus |
| line_lo | input | 1 | Digitised low leg of the bus |
| test_hi | input | 1 | Test stimulus high leg |
| test_lo | input | 1 | Test stimulus low leg |
| rd_done | input | 1 | Release of the buffered word after a full read |
| rd_part | input | 1 | Release of the buffered word after an incomplete read |
| word_avail | output | 1 | A word is waiting in the buffer |
| word_data | output | 32 | Buffered word, first received bit in bit 0 |
| err_code | output | 3 | Prioritised status of the buffered word |

## Verification
A word completion and a reader release can land on the same clock edge. That edge decides between an overrun, a clean hand-over, and a service-overrun mark on the new word. To provoke it, the bench first sends a reference word into an empty buffer and counts the clock edges from the end of its last bit until `word_avail` rises. It then replays identical words and places a one-cycle `rd_part` or `rd_done` pulse on exactly that edge. The result is judged at the ports: `word_avail` must stay high, `word_data` must show the new word, and `err_code` must read 001 or 000 rather than 100.

// File: rtl/a429_rx_pkg.sv
package a429_rx_pkg;
  localparam int unsigned WORD_BITS = 32;

  typedef enum logic [2:0] {
    ERR_NONE  = 3'b000,
    ERR_SVC   = 3'b001,
    ERR_PAR   = 3'b010,
    ERR_LEN   = 3'b011,
    ERR_OVR   = 3'b100,
    ERR_FAULT = 3'b111
  } a429_err_e;
endpackage

// File: rtl/a429_spike_filter.sv
module a429_spike_filter #(
  parameter int unsigned FILT_CLKS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int unsigned CW = $clog2(FILT_CLKS + 1);

  logic [1:0]    sync_q;
  logic          filt_q, filt_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // a level change is adopted only after FILT_CLKS consecutive disagreeing samples
  always_comb begin
    filt_d = filt_q;
    cnt_d  = '0;
    if (sync_q[1] != filt_q) begin
      if (cnt_q == CW'(FILT_CLKS - 1)) filt_d = sync_q[1];
      else                             cnt_d  = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      filt_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], din};
      filt_q <= filt_d;
      cnt_q  <= cnt_d;
    end
  end

  assign dout = filt_q;

  p_filt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_q[1] == filt_q) |=> $stable(filt_q));
endmodule

// File: rtl/a429_bit_framer.sv
module a429_bit_framer
  import a429_rx_pkg::*;
#(
  parameter int unsigned HS_BIT_CLKS = 16,
  parameter int unsigned LS_RATIO    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 speed_hi,
  input  logic                 lv_hi,
  input  logic                 lv_lo,
  output logic                 done,
  output logic [WORD_BITS-1:0] word,
  output logic                 len_ok,
  output logic                 par_ok,
  output logic                 fault
);
  localparam int unsigned GAP_HS = 2 * HS_BIT_CLKS;
  localparam int unsigned GAP_LS = GAP_HS * LS_RATIO;
  localparam int unsigned NW     = $clog2(GAP_LS + 1);
  localparam int unsigned BCW    = $clog2(WORD_BITS + 2);
  localparam int unsigned BCAP   = WORD_BITS + 1;

  logic                 act_q;
  logic [WORD_BITS-1:0] sreg_q, sreg_d;
  logic [BCW-1:0]       bcnt_q, bcnt_d;
  logic [NW-1:0]        nul_q, nul_d;
  logic                 flt_q, flt_d;
  logic [NW-1:0]        gap_lim;
  logic                 is_null, bit_ev, both_hi;

  assign gap_lim = speed_hi ? NW'(GAP_HS) : NW'(GAP_LS);
  assign is_null = !lv_hi && !lv_lo;
  assign both_hi = lv_hi && lv_lo;
  assign bit_ev  = !act_q && (lv_hi ^ lv_lo);
  assign done    = is_null && (nul_q == gap_lim - NW'(1)) &&
                   ((bcnt_q != '0) || flt_q);

  always_comb begin
    sreg_d = sreg_q;
    bcnt_d = bcnt_q;
    flt_d  = flt_q || both_hi;
    nul_d  = nul_q;
    if (!is_null)             nul_d = '0;
    else if (nul_q < gap_lim) nul_d = nul_q + NW'(1);
    if (done) begin
      sreg_d = '0;
      bcnt_d = '0;
      flt_d  = 1'b0;
    end else if (bit_ev) begin
      sreg_d = {lv_hi, sreg_q[WORD_BITS-1:1]};
      if (bcnt_q < BCW'(BCAP)) bcnt_d = bcnt_q + BCW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      sreg_q <= '0;
      bcnt_q <= '0;
      nul_q  <= '0;
      flt_q  <= 1'b0;
    end else begin
      act_q  <= lv_hi || lv_lo;
      sreg_q <= sreg_d;
      bcnt_q <= bcnt_d;
      nul_q  <= nul_d;
      flt_q  <= flt_d;
    end
  end

  assign word   = sreg_q;
  assign len_ok = (bcnt_q == BCW'(WORD_BITS));
  assign par_ok = ^sreg_q;
  assign fault  = flt_q;

  p_bcnt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt_q <= BCW'(BCAP));
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!lv_hi && !lv_lo));
  p_done_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (bcnt_q == '0) && !flt_q);
endmodule

// File: rtl/a429_rx_channel.sv
module a429_rx_channel
  import a429_rx_pkg::*;
#(
  parameter int unsigned HS_BIT_CLKS = 16,
  parameter int unsigned LS_RATIO    = 8,
  parameter int unsigned FILT_CLKS   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        speed_hi,
  input  logic        test_en,
  input  logic        line_hi,
  input  logic        line_lo,
  input  logic        test_hi,
  input  logic        test_lo,
  input  logic        rd_done,
  input  logic        rd_part,
  output logic        word_avail,
  output logic [31:0] word_data,
  output logic [2:0]  err_code
);
  logic [1:0] raw, flt;
  logic       fr_done, fr_len_ok, fr_par_ok, fr_fault;
  logic [WORD_BITS-1:0] fr_word;

  assign raw = test_en ? {test_hi, test_lo} : {line_hi, line_lo};

  for (genvar g = 0; g < 2; g++) begin : g_leg
    a429_spike_filter #(.FILT_CLKS(FILT_CLKS)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw[g]),
      .dout (flt[g])
    );
  end

  a429_bit_framer #(.HS_BIT_CLKS(HS_BIT_CLKS), .LS_RATIO(LS_RATIO)) u_framer (
    .clk     (clk),
    .rst_n   (rst_n),
    .speed_hi(speed_hi),
    .lv_hi   (flt[1]),
    .lv_lo   (flt[0]),
    .done    (fr_done),
    .word    (fr_word),
    .len_ok  (fr_len_ok),
    .par_ok  (fr_par_ok),
    .fault   (fr_fault)
  );

  logic                 avail_q, avail_d;
  logic [WORD_BITS-1:0] data_q, data_d;
  a429_err_e            code_q, code_d, code_new;
  logic                 svc_q, svc_d;
  logic                 release_ok, part_ok;

  assign release_ok = (rd_done || rd_part) && avail_q;
  assign part_ok    = rd_part && avail_q;

  always_comb begin
    if (fr_fault)                    code_new = ERR_FAULT;
    else if (avail_q && !release_ok) code_new = ERR_OVR;
    else if (!fr_len_ok)             code_new = ERR_LEN;
    else if (!fr_par_ok)             code_new = ERR_PAR;
    else if (svc_q || part_ok)       code_new = ERR_SVC;
    else                             code_new = ERR_NONE;
  end

  always_comb begin
    avail_d = avail_q;
    data_d  = data_q;
    code_d  = code_q;
    svc_d   = svc_q || part_ok;
    if (release_ok) avail_d = 1'b0;
    if (fr_done) begin
      avail_d = 1'b1;
      data_d  = fr_word;
      code_d  = code_new;
      svc_d   = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      avail_q <= 1'b0;
      data_q  <= '0;
      code_q  <= ERR_NONE;
      svc_q   <= 1'b0;
    end else begin
      avail_q <= avail_d;
      data_q  <= data_d;
      code_q  <= code_d;
      svc_q   <= svc_d;
    end
  end

  assign word_avail = avail_q;
  assign word_data  = data_q;
  assign err_code   = code_q;

  p_code_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 3'b101) && (err_code != 3'b110));
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_avail && !rd_done && !rd_part && !fr_done) |=> word_avail && $stable(word_data));
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (word_avail && (rd_done || rd_part) && !fr_done) |=> !word_avail);
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && word_avail && !rd_done && !rd_part && !fr_fault) |=> (err_code == 3'b100));
  p_same_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (fr_done && word_avail && (rd_done || rd_part)) |=> word_avail && (err_code != 3'b100));
endmodule

// File: tb/a429_rx_channel_tb.sv
module a429_rx_channel_tb;
  localparam int HS   = 16;
  localparam int LSR  = 8;
  localparam int FILT = 3;
  localparam int HALF_HS = HS / 2;
  localparam int HALF_LS = HS * LSR / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic speed_hi = 1'b1, test_en = 1'b0;
  logic line_hi = 1'b0, line_lo = 1'b0, test_hi = 1'b0, test_lo = 1'b0;
  logic rd_done = 1'b0, rd_part = 1'b0;
  logic        word_avail;
  logic [31:0] word_data;
  logic [2:0]  err_code;
  logic        use_tst = 1'b0;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  a429_rx_channel #(.HS_BIT_CLKS(HS), .LS_RATIO(LSR), .FILT_CLKS(FILT)) u_dut (
    .clk(clk), .rst_n(rst_n), .speed_hi(speed_hi), .test_en(test_en),
    .line_hi(line_hi), .line_lo(line_lo), .test_hi(test_hi), .test_lo(test_lo),
    .rd_done(rd_done), .rd_part(rd_part), .word_avail(word_avail),
    .word_data(word_data), .err_code(err_code));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic h, input logic l);
    if (use_tst) begin test_hi = h; test_lo = l; end
    else begin line_hi = h; line_lo = l; end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] w, input int n, input int half);
    for (int i = 0; i < n; i++) begin
      put(w[i % 32], !w[i % 32]);
      idle(half);
      put(1'b0, 1'b0);
      idle(half);
    end
  endtask

  task automatic pulse_done();
    rd_done = 1'b1; @(negedge clk); rd_done = 1'b0;
  endtask

  task automatic pulse_part();
    rd_part = 1'b1; @(negedge clk); rd_part = 1'b0;
  endtask

  function automatic logic [31:0] odd_fix(input logic [31:0] w);
    logic [31:0] r = w;
    r[31] = ~(^w[30:0]);
    return r;
  endfunction

  task automatic expect_word(input string req, input logic [31:0] d, input logic [2:0] c, input logic chk_d);
    chk({req, " avail"}, {31'd0, word_avail}, 32'd1);
    if (chk_d) chk({req, " data"}, word_data, d);
    chk({req, " code"}, {29'd0, err_code}, {29'd0, c});
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] w, a, b;
    int k;
    idle(3);
    // R1 reset state
    chk("R1 avail", {31'd0, word_avail}, 32'd0);
    chk("R1 data", word_data, 32'd0);
    chk("R1 code", {29'd0, err_code}, 32'd0);
    rst_n = 1'b1;
    idle(5);

    // R2 R3 R4 sweep over bit counts and parity
    for (int n = 29; n <= 35; n++) begin
      for (int e = 0; e < 2; e++) begin
        w = odd_fix(32'h5A3C_96E1 ^ (n << 9) ^ (e << 4));
        if (e == 1) w[31] = ~w[31];
        send_bits(w, n, HALF_HS);
        idle(64);
        if (n != 32) expect_word("R3", w, 3'b011, 1'b0);
        else if (e == 0) expect_word("R2", w, 3'b000, 1'b1);
        else expect_word("R4", w, 3'b010, 1'b1);
        pulse_done();
        chk("R8 cleared", {31'd0, word_avail}, 32'd0);
      end
    end
    send_bits(32'h1, 1, HALF_HS); idle(64);
    expect_word("R3 single bit", 32'h0, 3'b011, 1'b0);
    pulse_done();

    // R8 release with nothing buffered is ignored
    pulse_part(); pulse_done(); idle(3);
    chk("R8 idle release", {31'd0, word_avail}, 32'd0);
    w = odd_fix(32'h0F0F_1234);
    send_bits(w, 32, HALF_HS); idle(64);
    expect_word("R8 no mark", w, 3'b000, 1'b1);
    pulse_done();

    // R6 overrun
    a = odd_fix(32'h1111_2222); b = odd_fix(32'h3C3C_7001);
    send_bits(a, 32, HALF_HS); idle(64);
    send_bits(b, 32, HALF_HS); idle(64);
    expect_word("R6 overrun", b, 3'b100, 1'b1);
    pulse_done();

    // R7 partial release marks the next word only
    send_bits(a, 32, HALF_HS); idle(64);
    pulse_part();
    chk("R7 released", {31'd0, word_avail}, 32'd0);
    send_bits(b, 32, HALF_HS); idle(64);
    expect_word("R7 marked", b, 3'b001, 1'b1);
    pulse_done();
    send_bits(a, 32, HALF_HS); idle(64);
    expect_word("R7 next clean", a, 3'b000, 1'b1);
    pulse_done();

    // R5 fault outranks parity
    w = odd_fix(32'hDEAD_0BEE); w[31] = ~w[31];
    send_bits(w, 10, HALF_HS);
    put(1'b1, 1'b1); idle(HALF_HS); put(1'b0, 1'b0); idle(HALF_HS);
    send_bits(w >> 10, 22, HALF_HS); idle(64);
    expect_word("R5 fault", 32'h0, 3'b111, 1'b0);
    pulse_done();

    // R9 spike filter
    w = odd_fix(32'h2468_ACE1);
    put(1'b1, 1'b0); idle(FILT - 1); put(1'b0, 1'b0); idle(20);
    send_bits(w, 32, HALF_HS); idle(64);
    expect_word("R9 short spike", w, 3'b000, 1'b1);
    pulse_done();
    put(1'b1, 1'b0); idle(FILT + 2); put(1'b0, 1'b0); idle(20);
    send_bits(w, 32, HALF_HS); idle(64);
    expect_word("R9 long pulse", w, 3'b011, 1'b0);
    pulse_done();

    // R11 test pair selected, line leg held high
    test_en = 1'b1; use_tst = 1'b1; line_hi = 1'b1;
    idle(10);
    w = odd_fix(32'h7E57_0001);
    send_bits(w, 32, HALF_HS); idle(64);
    expect_word("R11 test pair", w, 3'b000, 1'b1);
    pulse_done();
    use_tst = 1'b0; line_hi = 1'b0; test_en = 1'b0; idle(80);
    chk("R11 no stray word", {31'd0, word_avail}, 32'd0);

    // R10 slow speed gap joins two fast bursts
    speed_hi = 1'b0;
    a = 32'h0000_5A5A; b = 32'h0000_1234;
    b[15] = ~(^{b[14:0], a[15:0]});
    send_bits(a, 16, HALF_HS); idle(64);
    chk("R10 not closed", {31'd0, word_avail}, 32'd0);
    send_bits(b, 16, HALF_HS); idle(300);
    expect_word("R10 joined", {b[15:0], a[15:0]}, 3'b000, 1'b1);
    pulse_done();
    w = odd_fix(32'hC001_D00D);
    send_bits(w, 32, HALF_LS); idle(300);
    expect_word("R10 slow word", w, 3'b000, 1'b1);
    pulse_done();
    speed_hi = 1'b1; idle(5);

    // R12 release on the completion edge, found by calibration
    a = odd_fix(32'hA0A0_0505);
    send_bits(a, 32, HALF_HS);
    k = 0;
    for (int t = 0; t < 200; t++) begin
      @(posedge clk); k++;
      @(negedge clk);
      if (word_avail) break;
    end
    expect_word("R12 reference", a, 3'b000, 1'b1);
    b = odd_fix(32'h0BAD_F00D);
    send_bits(b, 32, HALF_HS);
    idle(k - 1); pulse_part();
    expect_word("R12 part same edge", b, 3'b001, 1'b1);
    send_bits(a, 32, HALF_HS);
    idle(k - 1); pulse_done();
    expect_word("R12 done same edge", a, 3'b000, 1'b1);
    pulse_done();

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule